// File: doc/BRIEF.md
# Address Formation and Next-PC Unit

This block forms every memory address and every program-counter successor for a 16-bit load/store machine whose instruction word carries a 4-bit opcode in bits [15:12]. In each cycle it reads the instruction word, the already incremented program counter, one register value used as base or jump target, the shared data bus value and the one-hot negative/zero/positive condition flags. One cycle later it presents the memory address, the value that a load-effective-address instruction writes back, the program counter for the next instruction and a flag that says whether a branch was taken.

Two sign-extending adders do the arithmetic. One adds a 9-bit displacement to the incremented PC. The other adds a 6-bit displacement to the base register. Both wrap modulo 2^16. A decoder turns the opcode into an address source and a PC source. The address sources are: the PC-relative sum, the base-plus-offset sum, or a zero-extended 8-bit vector. The PC sources are: sequential, adder target, register, or bus. A branch evaluator ANDs the instruction's three mask bits with the flags. The decoder holds no state between cycles. The only state in the block is the output register.

Top module: `agu_top`

## Requirements
- R1: For opcodes 0010, 0011, 1010 and 1011, `eff_addr` equals `pc_inc` plus `instr[8:0]` sign-extended to 16 bits.
- R2: For opcodes 0110 and 0111, `eff_addr` equals `base_val` plus `instr[5:0]` sign-extended to 16 bits.
- R3: `lea_val` always equals `pc_inc` plus sign-extended `instr[8:0]`. For the load-effective-address opcode 1110, `eff_addr` carries the same value.
- R4: For the branch opcode 0000, the branch is taken exactly when `instr[11:9] & flags` is nonzero. Bit 2 is negative, bit 1 is zero and bit 0 is positive, in both the mask and the flags. A taken branch sets `next_pc` to the PC-relative sum of R1 and raises `br_taken`.
- R5: An untaken branch, and every opcode not named in R4, R7 or R8, sets `next_pc` to `pc_inc`. `br_taken` is high only for a taken branch.
- R6: A branch mask of 000 is never taken and a mask of 111 is always taken, whatever the one-hot flag value.
- R7: For the register jump opcode 1100, `next_pc` equals `base_val` and `br_taken` is low.
- R8: For the trap opcode 1111, `eff_addr` equals `instr[7:0]` zero-extended and `next_pc` equals `bus_val`.
- R9: All sums wrap modulo 2^16.
- R10: Every output is registered. It reflects the inputs of the previous rising clock edge, and it is zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Current instruction word |
| pc_inc | input | 16 | Program counter already incremented by fetch |
| base_val | input | 16 | Register value used as base or jump target |
| bus_val | input | 16 | Data bus value, used as trap target |
| flags | input | 3 | Condition flags {n,z,p}, one-hot |
| eff_addr | output | 16 | Effective memory address |
| lea_val | output | 16 | PC-relative sum for address writeback |
| next_pc | output | 16 | Program counter for the next instruction |
| br_taken | output | 1 | High when a branch was taken |

## Verification
The assertions assume that `flags` is one-hot. A machine always has exactly one of its three condition codes set. With any other flag value, the mask-111 property would not hold. Every scenario in the bench drives a single flag bit. It sets each input at the falling edge and holds it across the capturing rising edge. This keeps the one-cycle relation between `$past` inputs and the registered outputs exact. Properties check only on cycles whose previous edge was out of reset.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned OPC_W   = 4;

    typedef enum logic [1:0] {
        MAR_PCREL = 2'd0,
        MAR_BASE  = 2'd1,
        MAR_VEC   = 2'd2
    } mar_src_e;

    typedef enum logic [1:0] {
        PC_SEQ   = 2'd0,
        PC_ADDER = 2'd1,
        PC_REG   = 2'd2,
        PC_BUS   = 2'd3
    } pc_src_e;

    localparam logic [OPC_W-1:0] OP_BR  = 4'b0000;
    localparam logic [OPC_W-1:0] OP_LD  = 4'b0010;
    localparam logic [OPC_W-1:0] OP_ST  = 4'b0011;
    localparam logic [OPC_W-1:0] OP_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OP_STR = 4'b0111;
    localparam logic [OPC_W-1:0] OP_LDI = 4'b1010;
    localparam logic [OPC_W-1:0] OP_STI = 4'b1011;
    localparam logic [OPC_W-1:0] OP_JMP = 4'b1100;
    localparam logic [OPC_W-1:0] OP_LEA = 4'b1110;
    localparam logic [OPC_W-1:0] OP_TRP = 4'b1111;

endpackage

// File: rtl/agu_offset_adder.sv
module agu_offset_adder #(
    parameter int unsigned W     = 16,
    parameter int unsigned OFF_W = 9
) (
    input  logic [W-1:0]     base,
    input  logic [OFF_W-1:0] off,
    output logic [W-1:0]     sum
);
    localparam int unsigned EXT_W = W - OFF_W;

    logic [W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        sum     = base + off_ext;
    end
endmodule

// File: rtl/agu_decode.sv
module agu_decode
    import agu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             cond_hit,
    output mar_src_e         mar_sel,
    output pc_src_e          pc_sel,
    output logic             taken
);
    always_comb begin
        mar_sel = MAR_PCREL;
        pc_sel  = PC_SEQ;
        taken   = 1'b0;
        unique case (opcode)
            OP_BR: begin
                if (cond_hit) begin
                    pc_sel = PC_ADDER;
                    taken  = 1'b1;
                end
            end
            OP_LDR, OP_STR: mar_sel = MAR_BASE;
            OP_JMP:         pc_sel  = PC_REG;
            OP_TRP: begin
                mar_sel = MAR_VEC;
                pc_sel  = PC_BUS;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/agu_branch_eval.sv
module agu_branch_eval #(
    parameter int unsigned CC_W = 3
) (
    input  logic [CC_W-1:0] mask,
    input  logic [CC_W-1:0] cc,
    output logic            hit
);
    always_comb hit = |(mask & cc);
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned PCOFF_W = 9,
    parameter int unsigned BOFF_W  = 6,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned CC_W    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  instr,
    input  logic [W-1:0]  pc_inc,
    input  logic [W-1:0]  base_val,
    input  logic [W-1:0]  bus_val,
    input  logic [CC_W-1:0] flags,
    output logic [W-1:0]  eff_addr,
    output logic [W-1:0]  lea_val,
    output logic [W-1:0]  next_pc,
    output logic          br_taken
);
    localparam int unsigned OPC_LSB  = W - OPC_W;
    localparam int unsigned MASK_LSB = PCOFF_W;

    logic [W-1:0] pcrel_sum, base_sum, vec_ext;
    logic         cond_hit, taken_d;
    mar_src_e     mar_sel;
    pc_src_e      pc_sel;
    logic [W-1:0] ea_d, npc_d;

    agu_offset_adder #(.W(W), .OFF_W(PCOFF_W)) u_pcrel (
        .base (pc_inc),
        .off  (instr[PCOFF_W-1:0]),
        .sum  (pcrel_sum)
    );

    agu_offset_adder #(.W(W), .OFF_W(BOFF_W)) u_based (
        .base (base_val),
        .off  (instr[BOFF_W-1:0]),
        .sum  (base_sum)
    );

    agu_branch_eval #(.CC_W(CC_W)) u_br (
        .mask (instr[MASK_LSB +: CC_W]),
        .cc   (flags),
        .hit  (cond_hit)
    );

    agu_decode u_dec (
        .opcode   (instr[OPC_LSB +: OPC_W]),
        .cond_hit (cond_hit),
        .mar_sel  (mar_sel),
        .pc_sel   (pc_sel),
        .taken    (taken_d)
    );

    always_comb begin
        vec_ext = {{(W-VEC_W){1'b0}}, instr[VEC_W-1:0]};
        unique case (mar_sel)
            MAR_BASE: ea_d = base_sum;
            MAR_VEC:  ea_d = vec_ext;
            default:  ea_d = pcrel_sum;
        endcase
        unique case (pc_sel)
            PC_ADDER: npc_d = pcrel_sum;
            PC_REG:   npc_d = base_val;
            PC_BUS:   npc_d = bus_val;
            default:  npc_d = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_addr <= '0;
            lea_val  <= '0;
            next_pc  <= '0;
            br_taken <= 1'b0;
        end else begin
            eff_addr <= ea_d;
            lea_val  <= pcrel_sum;
            next_pc  <= npc_d;
            br_taken <= taken_d;
        end
    end
endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] instr,
    input logic [15:0] pc_inc,
    input logic [15:0] base_val,
    input logic [15:0] bus_val,
    input logic [2:0]  flags,
    input logic [15:0] eff_addr,
    input logic [15:0] lea_val,
    input logic [15:0] next_pc,
    input logic        br_taken
);
    // R4: a taken branch lands on the PC-relative target
    a_r4_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && br_taken) |->
        (next_pc == $past(pc_inc) + {{7{$past(instr[8])}}, $past(instr[8:0])}));

    // R5: br_taken only follows a branch opcode
    a_r5_taken_only_br: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && br_taken) |-> ($past(instr[15:12]) == 4'b0000));

    // R6: empty mask never taken
    a_r6_mask_none: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[11:9]) == 3'b000) |-> !br_taken);

    // R6: full mask taken under one-hot flags
    a_r6_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[15:9]) == 7'b0000111 && $onehot($past(flags)))
        |-> br_taken);

    // R7: register jump
    a_r7_jmp_reg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[15:12]) == 4'b1100)
        |-> (next_pc == $past(base_val) && !br_taken));

    // R8: trap vector zero-extended, PC from bus
    a_r8_trap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[15:12]) == 4'b1111)
        |-> (eff_addr == {8'h00, $past(instr[7:0])} && next_pc == $past(bus_val)));

    // R3: writeback value is the PC-relative sum
    a_r3_lea_sum: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (lea_val == $past(pc_inc) + {{7{$past(instr[8])}}, $past(instr[8:0])}));
endmodule

bind agu_top agu_top_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .bus_val  (bus_val),
    .flags    (flags),
    .eff_addr (eff_addr),
    .lea_val  (lea_val),
    .next_pc  (next_pc),
    .br_taken (br_taken)
);

// File: tb/agu_top_test.sv
module agu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0, pc_inc = '0, base_val = '0, bus_val = '0;
    logic [2:0]  flags = 3'b010;
    logic [15:0] eff_addr, lea_val, next_pc;
    logic        br_taken;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    agu_top uut (.clk(clk), .rst_n(rst_n), .instr(instr), .pc_inc(pc_inc),
        .base_val(base_val), .bus_val(bus_val), .flags(flags),
        .eff_addr(eff_addr), .lea_val(lea_val), .next_pc(next_pc),
        .br_taken(br_taken));

    function automatic logic [15:0] sx9(input logic [15:0] i);
        return {{7{i[8]}}, i[8:0]};
    endfunction
    function automatic logic [15:0] sx6(input logic [15:0] i);
        return {{10{i[5]}}, i[5:0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] i, input logic [15:0] pc,
                         input logic [15:0] b, input logic [15:0] bus, input logic [2:0] f);
        @(negedge clk);
        instr = i; pc_inc = pc; base_val = b; bus_val = bus; flags = f;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 reset eff_addr", eff_addr, 16'h0);
        chk("R10 reset next_pc", next_pc, 16'h0);
        chk("R10 reset br_taken", {15'h0, br_taken}, 16'h0);
    endtask

    task automatic t_pcrel();
        drive(16'h2000 | 16'h0FF, 16'h3001, 16'h1111, 16'h0, 3'b001);  // LD +255
        chk("R1 LD +255", eff_addr, 16'h3100);
        chk("R5 LD next_pc", next_pc, 16'h3001);
        drive(16'hB000 | 16'h100, 16'h3001, 16'h1111, 16'h0, 3'b001);  // STI -256
        chk("R1 STI -256", eff_addr, 16'h2F01);
    endtask

    task automatic t_baseoff();
        drive(16'h6000 | (3'd3 << 6) | 16'h3E, 16'h3000, 16'h4000, 16'h0, 3'b100);
        chk("R2 LDR -2", eff_addr, 16'h4000 + sx6(16'h3E));
        drive(16'h7000 | 16'h1F, 16'h3000, 16'h4000, 16'h0, 3'b100);
        chk("R2 STR +31", eff_addr, 16'h401F);
    endtask

    task automatic t_lea();
        drive(16'hE000 | 16'h1FD, 16'h30F7, 16'h0, 16'h0, 3'b010);
        chk("R3 lea_val", lea_val, 16'h30F4);
        chk("R3 LEA eff_addr", eff_addr, 16'h30F4);
    endtask

    task automatic t_branch();
        drive(16'h0000 | (3'b010 << 9) | 16'h005, 16'h3005, 16'h0, 16'h0, 3'b010);
        chk("R4 BRz taken pc", next_pc, 16'h300A);
        chk("R4 BRz taken flag", {15'h0, br_taken}, 16'h1);
        drive(16'h0000 | (3'b101 << 9) | 16'h005, 16'h3005, 16'h0, 16'h0, 3'b010);
        chk("R5 BRnp untaken pc", next_pc, 16'h3005);
        chk("R5 BRnp untaken flag", {15'h0, br_taken}, 16'h0);
        drive(16'h0000 | (3'b100 << 9) | 16'h1FA, 16'h300A, 16'h0, 16'h0, 3'b100);
        chk("R4 BRn back", next_pc, 16'h300A + sx9(16'h1FA));
    endtask

    task automatic t_mask_edges();
        for (int k = 0; k < 3; k++) begin
            drive(16'h0000 | 16'h010, 16'h2000, 16'h0, 16'h0, 3'b001 << k);
            chk("R6 mask 000 never", {15'h0, br_taken}, 16'h0);
            chk("R6 mask 000 pc", next_pc, 16'h2000);
            drive(16'h0E00 | 16'h010, 16'h2000, 16'h0, 16'h0, 3'b001 << k);
            chk("R6 mask 111 always", {15'h0, br_taken}, 16'h1);
            chk("R6 mask 111 pc", next_pc, 16'h2010);
        end
    endtask

    task automatic t_jmp();
        drive(16'hC000 | (3'd5 << 6), 16'h3000, 16'hBEEF, 16'h1234, 3'b001);
        chk("R7 jmp pc", next_pc, 16'hBEEF);
        chk("R7 jmp flag", {15'h0, br_taken}, 16'h0);
    endtask

    task automatic t_trap();
        drive(16'hF0A5, 16'h3011, 16'h7777, 16'h0520, 3'b001);
        chk("R8 trap vector", eff_addr, 16'h00A5);
        chk("R8 trap pc", next_pc, 16'h0520);
    endtask

    task automatic t_wrap();
        drive(16'h2000 | 16'h005, 16'hFFFE, 16'h0, 16'h0, 3'b001);
        chk("R9 pcrel wrap up", eff_addr, 16'h0003);
        drive(16'h6000 | 16'h20, 16'h0, 16'h0010, 16'h0, 3'b001);
        chk("R9 base wrap down", eff_addr, 16'hFFF0);
        drive(16'h0E00 | 16'h1FE, 16'h0001, 16'h0, 16'h0, 3'b001);
        chk("R9 branch wrap", next_pc, 16'hFFFF);
    endtask

    task automatic t_other();
        drive(16'h1000 | 16'h0E1F, 16'h4444, 16'h9999, 16'h8888, 3'b100);  // ADD-like
        chk("R5 other opcode pc", next_pc, 16'h4444);
        chk("R5 other opcode flag", {15'h0, br_taken}, 16'h0);
        chk("R10 one-cycle lea", lea_val, 16'h4444 + sx9(16'h0E1F));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pcrel();
        t_baseoff();
        t_lea();
        t_branch();
        t_mask_edges();
        t_jmp();
        t_trap();
        t_wrap();
        t_other();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule